// File: doc/BRIEF.md
# Interleaved multi-row multiply-accumulate element

This element computes one slice of a fully connected layer. A single weight column is combined with several input rows at the same time. Each weight that arrives is applied to `N_ROWS` consecutive inputs, and each of those inputs belongs to a different row slot. This gives `N_ROWS` independent running sums, and they take turns in a fixed-latency accumulate pipeline. As long as the pipeline latency `ADD_LAT` is no larger than `N_ROWS`, a slot's previous sum comes back just as its next product is ready. The element can then take one input per clock without stalling.

Every multiply-accumulate carries a tag: the input's index, the current output index and the row position inside the column. After `IN_DIM` weights the column is complete. The element then drains the per-slot sums as results, one per slot, in slot order. Each result carries the slot's input index and the column's output index. The output index begins at `OUT_BASE` and steps by `PE_STRIDE` after each column, which matches a bank of elements that split the output columns between them. Signed fixed point takes the place of floating point: 16-bit operands, 32-bit products and 40-bit accumulators that wrap.

All three data ports are valid/ready. A transfer happens on a rising edge where valid and ready are both high. A valid result stays presented, with its payload unchanged, until it is taken. While results are waiting, no input is accepted. The single weight register may still take the next column's first weight, and after that weight ready stays low. So back-pressure on the result port reaches the input port at once, and the weight port after one weight.

Top module: `mac_pe_top`

## Requirements
- R1: After reset, `w_ready` is 1, `x_ready` is 0 and `r_valid` is 0.
- R2: Each accepted weight is applied to exactly the next `N_ROWS` accepted inputs. The k-th of those inputs (k = 0 .. N_ROWS-1) belongs to row slot k.
- R3: The result for slot k is the sum, over the column's `IN_DIM` rows, of the sign-extended 32-bit product of weight and slot-k input. The sum is taken modulo 2^40 and is presented as a two's-complement value on `r_data`.
- R4: Each column's sums start from zero. A previous column's results have no effect on the next column's results.
- R5: A column ends after its `IN_DIM`-th weight has been used `N_ROWS` times. The element then presents exactly `N_ROWS` results, for slots 0, 1, …, N_ROWS-1 in that order.
- R6: `r_in_idx` of the slot-k result equals the `x_idx` that came with that slot's input on the column's final row.
- R7: `r_out_idx` is `OUT_BASE` for the first column after reset. It increases by `PE_STRIDE` (mod 256) after the last result of each column is taken.
- R8: When `ADD_LAT` ≤ `N_ROWS`, weights, inputs and results are always valid/ready, and the pipeline is empty at column start, the `N_ROWS*IN_DIM` inputs of a column are accepted on consecutive clock cycles.
- R9: While any result of a column is still waiting, `x_ready` is 0. At most one weight is accepted, and after that `w_ready` stays 0.
- R10: While `r_valid` is 1 and `r_ready` is 0, `r_valid`, `r_data`, `r_in_idx` and `r_out_idx` hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| w_valid | input | 1 | Weight offered |
| w_ready | output | 1 | Weight register can accept |
| w_data | input | 16 | Signed weight value |
| x_valid | input | 1 | Input value offered |
| x_ready | output | 1 | Input can be consumed by a MAC this cycle |
| x_data | input | 16 | Signed input value |
| x_idx | input | 8 | Input index carried with the value |
| r_valid | output | 1 | Result available |
| r_ready | input | 1 | Consumer takes the result |
| r_data | output | 40 | Signed accumulated sum |
| r_in_idx | output | 8 | Input index tag of the result |
| r_out_idx | output | 8 | Output index tag of the result |

## Verification
If the slot counter, the per-slot sums or the in-flight marks go wrong, the effect shows up within the same column. A mixed-up slot or a missed zero start gives a wrong `r_data` on the first result of that column. A wrong row count changes how many weights a column takes, which moves when results appear and what they add up to. A hazard between a sum in flight and the next issue shows as a stall inside a full-rate column, or as a sum that leaves out one product. Output-index stepping errors show up on the first result of the following column.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int DATA_W = 16;
  localparam int PROD_W = 32;
  localparam int ACC_W  = 40;
  localparam int IDX_W  = 8;
  localparam int ROW_W  = 16;
  localparam int SLOT_FIELD_W = 8;

  typedef struct packed {
    logic [IDX_W-1:0] in_idx;
    logic [IDX_W-1:0] out_idx;
    logic [ROW_W-1:0] row;
  } mac_tag_t;

  typedef struct packed {
    mac_tag_t                   tag;
    logic [SLOT_FIELD_W-1:0]    slot;
    logic signed [ACC_W-1:0]    sum;
  } pipe_word_t;
endpackage

// File: rtl/pe_tag_ctrl.sv
module pe_tag_ctrl
  import pe_pkg::*;
#(
  parameter int N_ROWS    = 8,
  parameter int IN_DIM    = 1024,
  parameter int PE_STRIDE = 8,
  parameter int OUT_BASE  = 0,
  localparam int SLOT_W   = $clog2(N_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_fire,
  input  logic              res_fire,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] drain_slot,
  output logic [ROW_W-1:0]  row,
  output logic [IDX_W-1:0]  out_idx,
  output logic              first_row,
  output logic              last_use,
  output logic              draining
);
  logic [SLOT_W-1:0] use_q, drn_q;
  logic [ROW_W-1:0]  row_q;
  logic [IDX_W-1:0]  out_q;
  logic              drain_q;
  logic              last_row, col_drained;

  assign last_use    = (use_q == SLOT_W'(N_ROWS - 1));
  assign last_row    = (row_q == ROW_W'(IN_DIM - 1));
  assign col_drained = res_fire && (drn_q == SLOT_W'(N_ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q   <= '0;
      row_q   <= '0;
      drn_q   <= '0;
      out_q   <= IDX_W'(OUT_BASE);
      drain_q <= 1'b0;
    end else begin
      if (mac_fire) begin
        if (last_use) begin
          use_q <= '0;
          row_q <= last_row ? '0 : row_q + 1'b1;
        end else begin
          use_q <= use_q + 1'b1;
        end
      end
      if (res_fire) drn_q <= col_drained ? '0 : drn_q + 1'b1;
      if (mac_fire && last_use && last_row) begin
        drain_q <= 1'b1;
      end else if (col_drained) begin
        drain_q <= 1'b0;
        out_q   <= out_q + IDX_W'(PE_STRIDE);
      end
    end
  end

  assign slot       = use_q;
  assign drain_slot = drn_q;
  assign row        = row_q;
  assign out_idx    = out_q;
  assign first_row  = (row_q == '0);
  assign draining   = drain_q;

  // R5: row position never reaches the column length
  a_r5_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    row_q < ROW_W'(IN_DIM));
  // R9: no MAC is issued while a column is being drained
  a_r9_no_mac_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> !mac_fire);
  // R5: results are only taken during a drain
  a_r5_result_only_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    res_fire |-> drain_q);
endmodule

// File: rtl/pe_add_pipe.sv
module pe_add_pipe
  import pe_pkg::*;
#(
  parameter int ADD_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  pipe_word_t in_word,
  output logic       out_valid,
  output pipe_word_t out_word
);
  logic       stg_v [ADD_LAT];
  pipe_word_t stg_w [ADD_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) stg_v[0] <= 1'b0;
    else        stg_v[0] <= in_valid;
    stg_w[0] <= in_word;
  end

  for (genvar g = 1; g < ADD_LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg_v[g] <= 1'b0;
      else        stg_v[g] <= stg_v[g-1];
      stg_w[g] <= stg_w[g-1];
    end
  end

  assign out_valid = stg_v[ADD_LAT-1];
  assign out_word  = stg_w[ADD_LAT-1];
endmodule

// File: rtl/pe_psum_bank.sv
module pe_psum_bank
  import pe_pkg::*;
#(
  parameter int N_ROWS  = 8,
  localparam int SLOT_W = $clog2(N_ROWS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [SLOT_W-1:0]       iss_slot,
  input  logic                    wb_valid,
  input  logic [SLOT_W-1:0]       wb_slot,
  input  logic signed [ACC_W-1:0] wb_sum,
  input  logic [IDX_W-1:0]        wb_idx,
  output logic                    iss_free,
  output logic signed [ACC_W-1:0] iss_base,
  input  logic [SLOT_W-1:0]       rd_slot,
  output logic                    rd_free,
  output logic signed [ACC_W-1:0] rd_sum,
  output logic [IDX_W-1:0]        rd_idx
);
  logic signed [ACC_W-1:0] sum_q [N_ROWS];
  logic [IDX_W-1:0]        idx_q [N_ROWS];
  logic [N_ROWS-1:0]       busy_q;
  logic                    wb_hit;

  assign wb_hit   = wb_valid && (wb_slot == iss_slot);
  assign iss_free = !busy_q[iss_slot] || wb_hit;
  assign iss_base = wb_hit ? wb_sum : sum_q[iss_slot];
  assign rd_free  = !busy_q[rd_slot];
  assign rd_sum   = sum_q[rd_slot];
  assign rd_idx   = idx_q[rd_slot];

  for (genvar s = 0; s < N_ROWS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[s] <= 1'b0;
        sum_q[s]  <= '0;
        idx_q[s]  <= '0;
      end else begin
        if (iss_valid && iss_slot == SLOT_W'(s))     busy_q[s] <= 1'b1;
        else if (wb_valid && wb_slot == SLOT_W'(s)) busy_q[s] <= 1'b0;
        if (wb_valid && wb_slot == SLOT_W'(s)) begin
          sum_q[s] <= wb_sum;
          idx_q[s] <= wb_idx;
        end
      end
    end
  end

  // R3: a writeback always lands on a slot that has a sum in flight
  a_r3_wb_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy_q[wb_slot]);
  // R3: a slot is never issued twice before its sum returns
  a_r3_no_double_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && busy_q[iss_slot]) |-> (wb_valid && wb_slot == iss_slot));
endmodule

// File: rtl/mac_pe_top.sv
module mac_pe_top
  import pe_pkg::*;
#(
  parameter int N_ROWS    = 8,
  parameter int ADD_LAT   = 4,
  parameter int IN_DIM    = 1024,
  parameter int PE_STRIDE = 8,
  parameter int OUT_BASE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [15:0]       w_data,
  input  logic              x_valid,
  output logic              x_ready,
  input  logic [15:0]       x_data,
  input  logic [7:0]        x_idx,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [39:0]       r_data,
  output logic [7:0]        r_in_idx,
  output logic [7:0]        r_out_idx
);
  localparam int SLOT_W = $clog2(N_ROWS);

  logic                    w_held;
  logic signed [DATA_W-1:0] w_q;
  logic [SLOT_W-1:0]       slot, drain_slot;
  logic [ROW_W-1:0]        row;
  logic [IDX_W-1:0]        out_idx;
  logic                    first_row, last_use, draining;
  logic                    mac_fire, res_fire, iss_free, rd_free;
  logic signed [ACC_W-1:0] iss_base, rd_sum, acc_in;
  logic signed [PROD_W-1:0] prod;
  logic [IDX_W-1:0]        rd_idx;
  pipe_word_t              in_word, out_word;
  logic                    out_valid;

  pe_tag_ctrl #(.N_ROWS(N_ROWS), .IN_DIM(IN_DIM), .PE_STRIDE(PE_STRIDE),
                .OUT_BASE(OUT_BASE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .mac_fire(mac_fire), .res_fire(res_fire),
    .slot(slot), .drain_slot(drain_slot), .row(row), .out_idx(out_idx),
    .first_row(first_row), .last_use(last_use), .draining(draining));

  assign x_ready  = !draining && w_held && iss_free;
  assign mac_fire = x_valid && x_ready;
  assign w_ready  = !w_held || (mac_fire && last_use);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_held <= 1'b0;
      w_q    <= '0;
    end else if (w_valid && w_ready) begin
      w_held <= 1'b1;
      w_q    <= signed'(w_data);
    end else if (mac_fire && last_use) begin
      w_held <= 1'b0;
    end
  end

  assign prod   = w_q * signed'(x_data);
  assign acc_in = (first_row ? '0 : iss_base) + ACC_W'(prod);

  always_comb begin
    in_word             = '0;
    in_word.tag.in_idx  = x_idx;
    in_word.tag.out_idx = out_idx;
    in_word.tag.row     = row;
    in_word.slot        = SLOT_FIELD_W'(slot);
    in_word.sum         = acc_in;
  end

  pe_add_pipe #(.ADD_LAT(ADD_LAT)) pipe_i (
    .clk(clk), .rst_n(rst_n), .in_valid(mac_fire), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word));

  pe_psum_bank #(.N_ROWS(N_ROWS)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(mac_fire), .iss_slot(slot),
    .wb_valid(out_valid), .wb_slot(out_word.slot[SLOT_W-1:0]),
    .wb_sum(out_word.sum), .wb_idx(out_word.tag.in_idx),
    .iss_free(iss_free), .iss_base(iss_base),
    .rd_slot(drain_slot), .rd_free(rd_free), .rd_sum(rd_sum), .rd_idx(rd_idx));

  assign r_valid   = draining && rd_free;
  assign res_fire  = r_valid && r_ready;
  assign r_data    = rd_sum;
  assign r_in_idx  = rd_idx;
  assign r_out_idx = out_idx;

  // R10: a stalled result keeps its payload
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_in_idx)
                               && $stable(r_out_idx)));
  // R9: an offered result blocks the input port
  a_r9_no_input_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !x_ready);
  // R2: a weight in use is not replaced before its last row slot
  a_r2_weight_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_fire && !last_use) |=> $stable(w_q));
  // R7: the output tag does not move while a column drains
  a_r7_out_idx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && $past(r_valid)) |-> $stable(r_out_idx));
endmodule

// File: tb/mac_pe_top_tb.sv
module mac_pe_top_tb_top;
  localparam int N = 4, L = 4, D = 5, STRIDE = 8, BASE = 3, NCOL = 7;
  localparam int NW = NCOL * D, NX = NCOL * D * N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic w_valid = 0, w_ready, x_valid = 0, x_ready, r_valid, r_ready = 0;
  logic [15:0] w_data = '0, x_data = '0;
  logic [7:0]  x_idx = '0, r_in_idx, r_out_idx;
  logic [39:0] r_data;

  int checks = 0, fails = 0, cyc = 0;
  logic signed [15:0] wv [NW];
  logic signed [15:0] xv [NX];
  logic [7:0]         xi [NX];
  int wi, xp, ri;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mac_pe_top #(.N_ROWS(N), .ADD_LAT(L), .IN_DIM(D), .PE_STRIDE(STRIDE),
               .OUT_BASE(BASE)) dut_i (.*);

  function automatic logic [39:0] exp_sum(int col, int s);
    longint acc = 0;
    for (int r = 0; r < D; r++)
      acc += longint'(wv[col*D+r]) * longint'(xv[(col*D+r)*N+s]);
    return acc[39:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // full: all handshakes always on; hold_n: stall first result that many cycles
  task automatic run_cols(int c0, int c1, bit full, int hold_n);
    int first_x = -1, last_x = -1, nx = 0, held = 0, w_in_hold = 0;
    logic [39:0] hd; logic [7:0] hi, ho;
    wi = c0 * D; xp = c0 * D * N; ri = c0 * N;
    while (ri < (c1 + 1) * N) begin
      @(posedge clk); #1;
      w_valid = (wi < (c1 + 1) * D) && (full || hold_n > 0 || ($urandom % 4 != 0));
      w_data  = (wi < NW) ? wv[wi] : '0;
      x_valid = (xp < (c1 + 1) * D * N) && (full || ($urandom % 4 != 0));
      x_data  = (xp < NX) ? xv[xp] : '0;
      x_idx   = (xp < NX) ? xi[xp] : '0;
      r_ready = (held > 0 && held <= hold_n) ? 1'b0 : (full || ($urandom % 3 != 0));
      @(negedge clk);
      if (held > 0 && held <= hold_n) begin
        // R10: stalled result unchanged; R9: input blocked
        check(r_valid && r_data == hd && r_in_idx == hi && r_out_idx == ho,
              "R10 hold", longint'(r_data), longint'(hd));
        check(!x_ready, "R9 x_ready in drain", x_ready, 0);
        if (w_valid && w_ready) w_in_hold++;
        held++;
        if (held > hold_n) begin
          check(w_in_hold <= 1 && !w_ready, "R9 weight stall", w_in_hold, 1);
        end
      end else if (r_valid && hold_n > 0 && held == 0) begin
        held = 1; hd = r_data; hi = r_in_idx; ho = r_out_idx;
        r_ready = 1'b0;
        continue;
      end
      if (w_valid && w_ready) wi++;
      if (x_valid && x_ready) begin
        if (first_x < 0 && full) first_x = cyc;
        last_x = cyc; nx++; xp++;
      end
      if (full && r_valid) check(!x_ready, "R9 x_ready with result", x_ready, 0);
      if (r_valid && r_ready) begin
        int col = ri / N, s = ri % N;
        logic [39:0] e = exp_sum(col, s);
        // R2 slot pairing and R4 zero start are both visible in this value
        check(r_data == e, $sformatf("R3/R4 col%0d slot%0d", col, s),
              longint'(r_data), longint'(e));
        check(r_in_idx == xi[(col*D+D-1)*N+s], "R6 in_idx (R5 order)",
              r_in_idx, xi[(col*D+D-1)*N+s]);
        check(r_out_idx == 8'(BASE + col * STRIDE), "R7 out_idx",
              r_out_idx, 8'(BASE + col * STRIDE));
        ri++;
      end
    end
    if (full) check(nx == N * D && last_x - first_x == N * D - 1,
                    "R8 consecutive inputs", last_x - first_x, N * D - 1);
    @(posedge clk); #1;
    w_valid = 0; x_valid = 0; r_ready = 0;
  endtask

  initial begin
    #(10 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd7731));
    for (int i = 0; i < NW; i++) wv[i] = 16'($urandom);
    for (int i = 0; i < NX; i++) begin
      xv[i] = 16'($urandom);
      xi[i] = 8'($urandom);
    end
    // column 0: extreme operands per slot
    for (int r = 0; r < D; r++) begin
      wv[r] = -16'sd32768;
      xv[r*N+0] = -16'sd32768;
      xv[r*N+1] = 16'sd32767;
      xv[r*N+2] = 16'sd0;
    end
    // column 2: fixed index per slot
    for (int i = 2*D*N; i < 3*D*N; i++) xi[i] = 8'(i % N + 100);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(w_ready && !x_ready && !r_valid, "R1 reset state",
          {w_ready, x_ready, r_valid}, 3'b100);

    run_cols(0, 3, 1'b0, 0);   // random handshakes, R2 R3 R4 R5 R6 R7
    run_cols(4, 4, 1'b1, 0);   // full rate, R8
    run_cols(5, 6, 1'b0, 12);  // result back-pressure, R9 R10
    finish_run();
  end
endmodule